// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading a translation tree held in memory. A walk starts at a per-context root descriptor and then descends through up to three levels of 4-byte descriptors. The level-1 table has 256 entries and is indexed by virtual bits 31:24. The level-2 table has 64 entries and is indexed by bits 23:18. The level-3 table has 64 entries and is indexed by bits 17:12. Bits 11:0 are the page offset. The two low bits of each descriptor give its kind. A descriptor that points to another table can be replaced at any level by a leaf, so one leaf can map 4 GB, 16 MB, 256 KB or 4 KB.

A client presents a request: a virtual address, a context number and a flag that marks the access as a store. It also supplies the context-table base register. The walker reads one descriptor at a time over a memory port that has a single outstanding access. It holds each access until the port acknowledges it. On a good leaf, the walker stores the entry back with the referenced bit set if that bit is clear. On a store, it also sets the modified bit if that bit is clear. It then reports the entry, the physical address, the level where the walk stopped and a fault code, all with a one-cycle done pulse.

The controller has four states. IDLE accepts a request (IDLE to READ). READ holds a descriptor read and moves when the read is acknowledged: to READ again for a table pointer, to WRITE for a leaf that needs its bits updated, or to DONE otherwise. WRITE holds the write-back and moves to DONE when the write is acknowledged. DONE raises the done pulse for one cycle and returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is in IDLE: req_ready is 1, and done and mem_req are 0.
- R2: The first read of a walk goes to address {ctx_base[31:4], 8'h00} + 4 × req_ctx. Bits 3:0 of ctx_base are ignored.
- R3: Descriptor type 1 is a table pointer. The next table starts at {entry[31:4], 8'h00}. The next read is at that base + 4 × index, where the index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R4: Descriptor type 2 read at level 3 is a leaf. The physical address is {entry[31:8], va[11:0]} and done_level is 3.
- R5: A type 2 leaf at a higher level maps a large region. At level 0 the physical address is {entry[31:28], va[31:0]}. At level 1 it is {entry[31:20], va[23:0]}. At level 2 it is {entry[31:14], va[17:0]}.
- R6: Descriptor type 0 ends the walk with done_code 1 at the level where it was read.
- R7: Descriptor type 3 ends the walk with done_code 2 at the level where it was read.
- R8: A table pointer read at level 3 ends the walk with done_code 3 and done_level 3.
- R9: A leaf whose referenced bit (bit 5) is clear, or a store to a leaf whose modified bit (bit 6) is clear, is written back to its own address. The written entry has bit 5 set, and bit 6 also set on a store. When no bit needs setting, no write is made. done_pte carries the entry as updated.
- R10: A faulting walk makes no write. It reports the entry it read in done_pte, with done_paddr 0 and done_fault 1. A good walk has done_fault 0 and done_code 0.
- R11: mem_req stays high with stable address and direction until mem_ack. Only one access is in flight at a time. done pulses for exactly one cycle, on the cycle after the last acknowledge.
- R12: req_ready is 1 only in IDLE. A request raised while a walk is in progress is ignored and starts no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | CTX_W | Context number |
| req_write | input | 1 | Request is a store |
| ctx_base | input | 32 | Context-table base, physical address >> 4 |
| mem_req | output | 1 | Memory access held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Byte address of descriptor |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access completed, read data valid |
| mem_rdata | input | 32 | Read descriptor |
| done | output | 1 | One-cycle completion pulse |
| done_pte | output | 32 | Final entry (updated leaf or faulting entry) |
| done_paddr | output | 36 | Translated physical address |
| done_level | output | 2 | Level at which the walk ended (0 to 3) |
| done_fault | output | 1 | Walk faulted |
| done_code | output | 2 | 0 none, 1 invalid, 2 reserved type, 3 pointer at level 3 |

## Verification
The first descriptor read starts on the cycle after the request is accepted. Each further access follows the cycle after the acknowledge of the access before it. done rises exactly one cycle after the final acknowledge, whether that acknowledge completes a read or a write-back. The bench's memory responder compares every access against a queue of addresses, directions and write data that the behavioural model predicts, at the moment the access is acknowledged. The bench checks the cycle of the done pulse against the cycle of the last acknowledge and compares req_ready with the model's busy flag on every clock. The acknowledge latency changes from walk to walk, so each of these offsets is checked under different amounts of waiting.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 36;
    localparam int DESC_W = 32;
    localparam int OFF_W  = 12;
    localparam int L3_W   = 6;
    localparam int L2_W   = 6;
    localparam int L1_W   = 8;
    localparam int L3_LSB = OFF_W;
    localparam int L2_LSB = L3_LSB + L3_W;
    localparam int L1_LSB = L2_LSB + L2_W;
    localparam int PTR_LSB = 4;
    localparam int TBL_ALIGN = PA_W - (DESC_W - PTR_LSB);
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam logic [1:0] LAST_LVL = 2'd3;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_TABLE   = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_RSVD    = 2'd2,
        FLT_DEPTH   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_DONE  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/ptw_desc_addr.sv
module ptw_desc_addr
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [1:0]        level,
    input  logic [PA_W-1:0]   tbl_base,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [CTX_W-1:0]  ctx,
    output logic [PA_W-1:0]   desc_addr
);
    localparam int DESC_SHIFT = $clog2(DESC_W / 8);

    logic [PA_W-1:0] idx_ext;
    logic            unused_off;

    assign unused_off = ^vaddr[OFF_W-1:0];

    always_comb begin
        unique case (level)
            2'd0: idx_ext = PA_W'(ctx);
            2'd1: idx_ext = PA_W'(vaddr[L1_LSB +: L1_W]);
            2'd2: idx_ext = PA_W'(vaddr[L2_LSB +: L2_W]);
            2'd3: idx_ext = PA_W'(vaddr[L3_LSB +: L3_W]);
        endcase
    end

    assign desc_addr = tbl_base + (idx_ext << DESC_SHIFT);
endmodule

// File: rtl/ptw_classify.sv
module ptw_classify
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] entry,
    input  logic [1:0]        level,
    input  logic              is_store,
    output logic              go_down,
    output logic              is_leaf,
    output fault_e            fault,
    output logic              need_wb,
    output logic [DESC_W-1:0] upd_entry
);
    etype_e et;
    logic [DESC_W-1:0] set_mask;

    assign et = etype_e'(entry[1:0]);

    always_comb begin
        go_down = 1'b0;
        is_leaf = 1'b0;
        fault   = FLT_NONE;
        unique case (et)
            ET_INVALID: fault = FLT_INVALID;
            ET_RSVD:    fault = FLT_RSVD;
            ET_TABLE: begin
                if (level == LAST_LVL) fault = FLT_DEPTH;
                else                   go_down = 1'b1;
            end
            ET_LEAF:    is_leaf = 1'b1;
        endcase
    end

    always_comb begin
        set_mask = '0;
        set_mask[REF_BIT] = 1'b1;
        set_mask[MOD_BIT] = is_store;
    end

    assign upd_entry = entry | set_mask;
    assign need_wb   = is_leaf && (upd_entry != entry);
endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] entry,
    input  logic [1:0]        level,
    input  logic [VA_W-1:0]   vaddr,
    output logic [PA_W-1:0]   paddr
);
    logic unused_flags;
    assign unused_flags = ^entry[7:0];

    always_comb begin
        unique case (level)
            2'd0: paddr = {entry[DESC_W-1 -: (PA_W - VA_W)],   vaddr};
            2'd1: paddr = {entry[DESC_W-1 -: (PA_W - L1_LSB)], vaddr[L1_LSB-1:0]};
            2'd2: paddr = {entry[DESC_W-1 -: (PA_W - L2_LSB)], vaddr[L2_LSB-1:0]};
            2'd3: paddr = {entry[DESC_W-1 -: (PA_W - OFF_W)],  vaddr[OFF_W-1:0]};
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_write,
    input  logic [31:0]       ctx_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [35:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [31:0]       done_pte,
    output logic [35:0]       done_paddr,
    output logic [1:0]        done_level,
    output logic              done_fault,
    output logic [1:0]        done_code
);
    walk_state_e state_q, state_d;

    logic [VA_W-1:0]   va_q;
    logic [CTX_W-1:0]  ctx_q;
    logic              wr_q;
    logic [1:0]        lvl_q;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   wb_addr_q;
    logic [DESC_W-1:0] res_pte_q;
    logic [PA_W-1:0]   res_pa_q;
    logic [1:0]        res_lvl_q;
    fault_e            res_code_q;

    logic [PA_W-1:0]   desc_addr;
    logic [PA_W-1:0]   leaf_pa;
    logic              go_down, is_leaf, need_wb;
    fault_e            flt;
    logic [DESC_W-1:0] upd_entry;
    logic              unused_base;

    assign unused_base = ^ctx_base[PTR_LSB-1:0];

    ptw_desc_addr #(.CTX_W(CTX_W)) u_addr (
        .level    (lvl_q),
        .tbl_base (base_q),
        .vaddr    (va_q),
        .ctx      (ctx_q),
        .desc_addr(desc_addr)
    );

    ptw_classify u_cls (
        .entry    (mem_rdata),
        .level    (lvl_q),
        .is_store (wr_q),
        .go_down  (go_down),
        .is_leaf  (is_leaf),
        .fault    (flt),
        .need_wb  (need_wb),
        .upd_entry(upd_entry)
    );

    ptw_leaf_pa u_pa (
        .entry(mem_rdata),
        .level(lvl_q),
        .vaddr(va_q),
        .paddr(leaf_pa)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_READ;
            S_READ: begin
                if (mem_ack) begin
                    if (go_down)      state_d = S_READ;
                    else if (need_wb) state_d = S_WRITE;
                    else              state_d = S_DONE;
                end
            end
            S_WRITE: if (mem_ack) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            ctx_q      <= '0;
            wr_q       <= 1'b0;
            lvl_q      <= '0;
            base_q     <= '0;
            wb_addr_q  <= '0;
            res_pte_q  <= '0;
            res_pa_q   <= '0;
            res_lvl_q  <= '0;
            res_code_q <= FLT_NONE;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                ctx_q  <= req_ctx;
                wr_q   <= req_write;
                lvl_q  <= 2'd0;
                base_q <= {ctx_base[DESC_W-1:PTR_LSB], TBL_ALIGN'(0)};
            end
            if (state_q == S_READ && mem_ack) begin
                if (go_down) begin
                    base_q <= {mem_rdata[DESC_W-1:PTR_LSB], TBL_ALIGN'(0)};
                    lvl_q  <= lvl_q + 2'd1;
                end else begin
                    res_pte_q  <= is_leaf ? upd_entry : mem_rdata;
                    res_pa_q   <= is_leaf ? leaf_pa : '0;
                    res_lvl_q  <= lvl_q;
                    res_code_q <= flt;
                    wb_addr_q  <= desc_addr;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        mem_addr  = desc_addr;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_READ:  mem_req = 1'b1;
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = wb_addr_q;
            end
            S_DONE:  done = 1'b1;
        endcase
    end

    assign mem_wdata  = res_pte_q;
    assign done_pte   = res_pte_q;
    assign done_paddr = res_pa_q;
    assign done_level = res_lvl_q;
    assign done_code  = res_code_q;
    assign done_fault = (res_code_q != FLT_NONE);

    // R11: a held access keeps its address and direction until acknowledged
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11: completion follows an acknowledge by one cycle
    a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_ack));

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: ready only when nothing is in flight
    a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !done);

    // R8: depth fault only at the last level
    a_r8_depth_level: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_code == 2'd3 |-> done_level == 2'd3);

    // R5: a good walk always ends on a leaf descriptor
    a_r5_leaf_result: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault |-> done_pte[1:0] == 2'b10);

    // R9: any write-back carries the referenced bit
    a_r9_wb_ref: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5]);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_ctx = '0;
    logic        req_write = 1'b0;
    logic [31:0] ctx_base = '0;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] done_pte;
    logic [35:0] done_paddr;
    logic [1:0]  done_level;
    logic        done_fault;
    logic [1:0]  done_code;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_ctx(req_ctx), .req_write(req_write), .ctx_base(ctx_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .done_pte(done_pte), .done_paddr(done_paddr),
        .done_level(done_level), .done_fault(done_fault), .done_code(done_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ack_cyc = -10;
    int lat = 0;
    int wait_cnt = 0;
    bit busy = 0;
    bit exp_pending = 0;
    bit finished = 0;
    string cur_tag = "R4";

    logic [31:0] mem [logic [35:0]];
    logic [35:0] q_addr [$];
    bit          q_we   [$];
    logic [31:0] q_wd   [$];

    logic [31:0] e_pte;
    logic [35:0] e_pa;
    logic [1:0]  e_lvl;
    logic [1:0]  e_code;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] rd(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] ptd(input logic [35:0] pa);
        return {pa[35:8], 4'b0001};
    endfunction

    function automatic logic [31:0] leaf(input logic [35:0] pa, input logic [7:0] fl);
        return {pa[35:12], fl[7:2], 2'b10};
    endfunction

    // behavioural reference walk
    task automatic model(input logic [31:0] va, input logic [7:0] ctx, input bit wr);
        logic [35:0] base, a;
        logic [31:0] e, nb;
        int idx;
        base = {ctx_base[31:4], 8'h00};
        idx = ctx;
        for (int l = 0; l < 4; l++) begin
            a = base + 36'(idx * 4);
            q_addr.push_back(a); q_we.push_back(0); q_wd.push_back(0);
            e = rd(a);
            e_lvl = 2'(l);
            if (e[1:0] == 2'd0) begin e_code = 1; e_pte = e; e_pa = 0; break; end
            if (e[1:0] == 2'd3) begin e_code = 2; e_pte = e; e_pa = 0; break; end
            if (e[1:0] == 2'd1) begin
                if (l == 3) begin e_code = 3; e_pte = e; e_pa = 0; break; end
                base = {e[31:4], 8'h00};
                idx = (l == 0) ? int'(va[31:24]) : (l == 1) ? int'(va[23:18]) : int'(va[17:12]);
                continue;
            end
            nb = e | 32'h20 | (wr ? 32'h40 : 32'h0);
            if (nb != e) begin q_addr.push_back(a); q_we.push_back(1); q_wd.push_back(nb); end
            e_pte = nb; e_code = 0;
            case (l)
                0: e_pa = {e[31:28], va};
                1: e_pa = {e[31:20], va[23:0]};
                2: e_pa = {e[31:14], va[17:0]};
                default: e_pa = {e[31:8], va[11:0]};
            endcase
            break;
        end
    endtask

    // memory responder and per-clock comparisons
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(req_ready === !busy, "R12 ready", 64'(req_ready), 64'(!busy));
            if (mem_ack) mem_ack <= 1'b0;
            else if (mem_req) begin
                if (wait_cnt < lat) wait_cnt <= wait_cnt + 1;
                else begin
                    wait_cnt <= 0;
                    if (q_addr.size() == 0) begin
                        check(0, "R12 unexpected access", 64'(mem_addr), 64'h0);
                    end else begin
                        check(mem_addr === q_addr[0], "R2 R3 R11 addr", 64'(mem_addr), 64'(q_addr[0]));
                        check(mem_we === q_we[0], "R9 R10 direction", 64'(mem_we), 64'(q_we[0]));
                        if (q_we[0]) check(mem_wdata === q_wd[0], "R9 wdata", 64'(mem_wdata), 64'(q_wd[0]));
                        void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_wd.pop_front());
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    mem_rdata <= rd(mem_addr);
                    mem_ack <= 1'b1;
                    ack_cyc = cyc;
                end
            end
            if (done) begin
                check(exp_pending, "R12 spurious done", 64'(done), 64'(0));
                check(cyc == ack_cyc + 1, "R11 done timing", 64'(cyc), 64'(ack_cyc + 1));
                check(q_addr.size() == 0, "R11 missing access", 64'(q_addr.size()), 64'h0);
                check(done_pte === e_pte, {cur_tag, " pte"}, 64'(done_pte), 64'(e_pte));
                check(done_paddr === e_pa, {cur_tag, " paddr"}, 64'(done_paddr), 64'(e_pa));
                check(done_level === e_lvl, {cur_tag, " level"}, 64'(done_level), 64'(e_lvl));
                check(done_code === e_code, {cur_tag, " code"}, 64'(done_code), 64'(e_code));
                check(done_fault === (e_code != 0), "R10 fault flag", 64'(done_fault), 64'(e_code != 0));
                exp_pending = 0;
                busy = 0;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [7:0] ctx, input bit wr,
                        input int l, input bit poke, input string tag);
        cur_tag = tag;
        lat = l;
        model(va, ctx, wr);
        exp_pending = 1;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_ctx = ctx; req_write = wr;
        @(posedge clk);
        busy = 1;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            // R12: a request while busy must be ignored
            @(negedge clk);
            req_valid = 1; req_vaddr = 32'hFFFF_F000; req_ctx = 8'd9; req_write = 1;
            @(negedge clk);
            req_valid = 0;
        end
        while (exp_pending) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    localparam logic [35:0] ROOT = 36'h0_0001_0000;
    localparam logic [35:0] L1A  = 36'h0_0002_0000;
    localparam logic [35:0] L2A  = 36'h0_0003_0000;
    localparam logic [35:0] L3A  = 36'h0_0004_0000;

    initial begin
        logic [31:0] va1;
        va1 = 32'h1234_5678;
        // low nibble set to show it is ignored (R2)
        ctx_base = {ROOT[35:8], 4'hF};
        mem[ROOT + 0]  = ptd(L1A);
        mem[ROOT + 8]  = ptd(L1A);
        mem[ROOT + 20] = leaf(36'hA_0000_0000, 8'h20);
        mem[L1A + 36'(va1[31:24]) * 4] = ptd(L2A);
        mem[L2A + 36'(va1[23:18]) * 4] = ptd(L3A);
        mem[L3A + 36'(va1[17:12]) * 4] = leaf(36'h9_ABCD_E000, 8'h88);
        mem[L2A + 36'h3F * 4] = leaf(36'h8_1240_0000, 8'hA4);
        mem[L1A + 36'h56 * 4] = leaf(36'h7_0100_0000, 8'h8C);
        mem[L2A + 36'h30 * 4] = 32'h0000_1233;
        mem[L3A + 36'h06 * 4] = ptd(36'h0_0006_0000);

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        check(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'h1);
        check(done === 1'b0, "R1 done", 64'(done), 64'h0);
        check(mem_req === 1'b0, "R1 mem_req", 64'(mem_req), 64'h0);

        walk(va1, 8'd0, 0, 0, 0, "R4 R9");           // full walk, referenced bit set by write-back
        walk(va1, 8'd0, 0, 2, 0, "R4 R9");           // bit already set: no write
        walk(va1, 8'd0, 1, 1, 0, "R9");              // store sets modified bit
        walk(32'h12FF_F123, 8'd0, 0, 1, 0, "R5");    // level-2 leaf, no write
        walk(32'h5600_0ABC, 8'd0, 1, 0, 0, "R5 R9"); // level-1 leaf, store
        walk(32'hDEAD_BEEF, 8'd5, 0, 2, 0, "R5 R2"); // context-level leaf
        walk(32'h7700_0000, 8'd0, 0, 0, 0, "R6");    // invalid at level 1
        walk(32'h0000_1000, 8'd3, 1, 1, 0, "R6 R10");// invalid root
        walk(32'h12C0_0000, 8'd0, 1, 0, 0, "R7");    // reserved type at level 2
        walk(32'h1234_6000, 8'd0, 0, 3, 0, "R8");    // pointer at level 3
        walk(va1, 8'd2, 0, 3, 1, "R3 R12");          // other context, poke while busy
        repeat (5) @(negedge clk);
        summary();
    end
endmodule